// File: doc/BRIEF.md
# PCI Configuration Cycle Address Generator

This block accepts one configuration-access request at a time and turns it into the address phase of a PCI configuration cycle. Each request carries bus, device, function and register-number fields, a read/write flag and write data. A zero bus number produces a Type 0 cycle with one-hot IDSEL selection. A non-zero bus number produces a Type 1 cycle that a bridge forwards. A Type 0 request to device 0 addresses the local function and completes internally, with no bus activity.

External cycles drive the address for a few stepping clocks before FRAME, so IDSEL can settle. A single data phase follows, with IRDY asserted and FRAME already released. A simple claim model watches DEVSEL and TRDY from the target. If no target claims the cycle inside a fixed window, the cycle ends as a master abort and a sticky status bit is set. Completion is reported through busy, done and error outputs for a decoupled caller.

Top module: `cfg_cycle_gen`

## Requirements
- R1: For a non-zero bus number the address phase drives AD = {1'b0, 7'b0, bus[7:0], dev[4:0], fn[2:0], reg[5:0], 2'b01}.
- R2: For bus 0 and a non-zero device, the address phase drives AD = {21 ones, fn[2:0], reg[5:0], 2'b00}.
- R3: In a Type 0 address phase, device n in 1..21 asserts only idsel_o bit n-1. Devices 22..31, every Type 1 cycle, and every clock outside the address phase assert no IDSEL bit.
- R4: A request with bus 0 and device 0 gives done_o and local_o together on the clock after acceptance. It gives no busy_o, no frame_o and no AD drive.
- R5: The address is driven with frame_o low for exactly STEP_CYC (2) clocks. frame_o is then high for exactly one clock.
- R6: cbe_o is 4'hA for a read and 4'hB for a write during address clocks, and 4'h0 during the data phase.
- R7: After the frame clock, irdy_o is high and frame_o low until completion. A write drives its data on AD. A read captures rdata_i on the clock where DEVSEL and TRDY are both seen, and presents it on rdata_o with done_o.
- R8: If devsel_i is not seen in any of the DEVSEL_WIN (5) data clocks after the frame clock, the cycle ends with done_o and err_o. rma_o then sets and stays set until rma_clr_i is pulsed.
- R9: busy_o is high from the clock after acceptance until completion. done_o is a one-clock pulse. err_o is high only with done_o on an abort.
- R10: A request raised while busy_o is high is ignored: the cycle in progress keeps its address and no new cycle follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, accepted when not busy |
| we_i | input | 1 | 1 = configuration write |
| bus_i | input | 8 | Bus number |
| dev_i | input | 5 | Device number |
| fn_i | input | 3 | Function number |
| reg_i | input | 6 | Dword register number |
| wdata_i | input | 32 | Write data |
| devsel_i | input | 1 | Target claim (active high model) |
| trdy_i | input | 1 | Target ready (active high model) |
| rdata_i | input | 32 | Read data from target |
| rma_clr_i | input | 1 | Clears the sticky master-abort bit |
| ad_o | output | 32 | AD bus value |
| ad_oe_o | output | 1 | AD drive enable |
| cbe_o | output | 4 | Command / byte enables |
| frame_o | output | 1 | FRAME (active high) |
| irdy_o | output | 1 | IRDY (active high) |
| idsel_o | output | 21 | One-hot IDSEL lines |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Abort flag, valid with done_o |
| local_o | output | 1 | Local (self-targeted) completion pulse |
| rdata_o | output | 32 | Captured read data |
| rma_o | output | 1 | Sticky received-master-abort bit |

## Verification
Every device number from 0 to 31 is swept with bus 0, a small bus number and bus 255, and reads and writes alternate. The bus values separate the Type 0 and Type 1 encodings. The device sweep covers the local short-circuit, each IDSEL position and the invalid range. Claim delays from 1 to 7 clocks place DEVSEL at both edges of the five-clock window and beyond it, which separates normal completion from a master abort. A request raised in mid-cycle with different fields shows whether the latched address or the queue state is disturbed.

// File: rtl/cfgc_pkg.sv
package cfgc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_STEP, ST_ADDR, ST_DATA} cfg_st_e;
  localparam logic [3:0] CMD_CFG_RD = 4'hA;
  localparam logic [3:0] CMD_CFG_WR = 4'hB;
endpackage

// File: rtl/cfgc_addr.sv
module cfgc_addr #(
  parameter int NUM_IDSEL = 21
) (
  input  logic [7:0]           bus_i,
  input  logic [4:0]           dev_i,
  input  logic [2:0]           fn_i,
  input  logic [5:0]           reg_i,
  output logic [31:0]          ad_o,
  output logic [NUM_IDSEL-1:0] idsel_o,
  output logic                 type1_o,
  output logic                 local_o
);
  localparam int UPPER_W = 32 - 11;

  assign type1_o = |bus_i;
  assign local_o = !type1_o && (dev_i == 5'd0);
  assign ad_o = type1_o ? {1'b0, 7'b0, bus_i, dev_i, fn_i, reg_i, 2'b01}
                        : {{UPPER_W{1'b1}}, fn_i, reg_i, 2'b00};

  for (genvar g = 0; g < NUM_IDSEL; g++) begin : g_idsel
    assign idsel_o[g] = !type1_o && (dev_i == 5'(g + 1));
  end

  always_comb begin
    p_idsel_onehot_r3: assert ($onehot0(idsel_o));
    p_idsel_type1_r3:  assert (!type1_o || idsel_o == '0);
  end
endmodule

// File: rtl/cfgc_seq.sv
module cfgc_seq
  import cfgc_pkg::*;
#(
  parameter int STEP_CYC   = 2,
  parameter int DEVSEL_WIN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic local_i,
  input  logic devsel_i,
  input  logic trdy_i,
  input  logic rma_clr_i,
  output logic addr_ph_o,
  output logic data_ph_o,
  output logic frame_o,
  output logic xfer_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o,
  output logic local_o,
  output logic rma_o
);
  localparam int MAXC  = (STEP_CYC > DEVSEL_WIN) ? STEP_CYC : DEVSEL_WIN;
  localparam int CNT_W = $clog2(MAXC + 1);

  cfg_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             claimed_q, done_q, err_q, loc_q, rma_q;
  logic             claim_now, abort_now;

  assign claim_now = claimed_q || devsel_i;
  assign xfer_o    = (st_q == ST_DATA) && claim_now && trdy_i;
  assign abort_now = (st_q == ST_DATA) && !claim_now && (cnt_q == CNT_W'(DEVSEL_WIN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      claimed_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      loc_q     <= 1'b0;
      rma_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      loc_q  <= 1'b0;
      if (rma_clr_i) rma_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q  <= ST_STEP;
            cnt_q <= '0;
          end else if (local_i) begin
            done_q <= 1'b1;
            loc_q  <= 1'b1;
          end
        end
        ST_STEP: begin
          if (cnt_q == CNT_W'(STEP_CYC - 1)) st_q <= ST_ADDR;
          else cnt_q <= cnt_q + 1'b1;
        end
        ST_ADDR: begin
          st_q      <= ST_DATA;
          cnt_q     <= CNT_W'(1);
          claimed_q <= 1'b0;
        end
        ST_DATA: begin
          if (devsel_i) claimed_q <= 1'b1;
          if (xfer_o) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else if (abort_now) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
            err_q  <= 1'b1;
            rma_q  <= 1'b1;  // set wins over clear
          end else if (!claim_now) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign addr_ph_o = (st_q == ST_STEP) || (st_q == ST_ADDR);
  assign data_ph_o = (st_q == ST_DATA);
  assign frame_o   = (st_q == ST_ADDR);
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign local_o   = loc_q;
  assign rma_o     = rma_q;

  p_frame_one_clk_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> !frame_o);
  p_step_before_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_o) |-> $past(addr_ph_o));
  p_abort_sets_rma_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> rma_o);
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_err_with_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  p_local_not_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    local_o |-> (!busy_o && !err_o));
  p_data_after_frame_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> data_ph_o);
endmodule

// File: rtl/cfg_cycle_gen.sv
module cfg_cycle_gen
  import cfgc_pkg::*;
#(
  parameter int NUM_IDSEL  = 21,
  parameter int STEP_CYC   = 2,
  parameter int DEVSEL_WIN = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [7:0]           bus_i,
  input  logic [4:0]           dev_i,
  input  logic [2:0]           fn_i,
  input  logic [5:0]           reg_i,
  input  logic [31:0]          wdata_i,
  input  logic                 devsel_i,
  input  logic                 trdy_i,
  input  logic [31:0]          rdata_i,
  input  logic                 rma_clr_i,
  output logic [31:0]          ad_o,
  output logic                 ad_oe_o,
  output logic [3:0]           cbe_o,
  output logic                 frame_o,
  output logic                 irdy_o,
  output logic [NUM_IDSEL-1:0] idsel_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 err_o,
  output logic                 local_o,
  output logic [31:0]          rdata_o,
  output logic                 rma_o
);
  logic [31:0]          ad_c, ad_q, wdata_q, rdata_q;
  logic [NUM_IDSEL-1:0] idsel_c, idsel_q;
  logic                 type1_c, local_c, we_q;
  logic                 accept, addr_ph, data_ph, xfer;

  cfgc_addr #(.NUM_IDSEL(NUM_IDSEL)) u_addr (
    .bus_i(bus_i), .dev_i(dev_i), .fn_i(fn_i), .reg_i(reg_i),
    .ad_o(ad_c), .idsel_o(idsel_c), .type1_o(type1_c), .local_o(local_c)
  );

  assign accept = req_i && !busy_o;

  cfgc_seq #(.STEP_CYC(STEP_CYC), .DEVSEL_WIN(DEVSEL_WIN)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(accept && !local_c), .local_i(accept && local_c),
    .devsel_i(devsel_i), .trdy_i(trdy_i), .rma_clr_i(rma_clr_i),
    .addr_ph_o(addr_ph), .data_ph_o(data_ph), .frame_o(frame_o), .xfer_o(xfer),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .local_o(local_o),
    .rma_o(rma_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ad_q    <= '0;
      idsel_q <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept && !local_c) begin
        ad_q    <= ad_c;
        idsel_q <= idsel_c;
        we_q    <= we_i;
        wdata_q <= wdata_i;
      end
      if (xfer && !we_q) rdata_q <= rdata_i;
    end
  end

  assign ad_oe_o = addr_ph || (data_ph && we_q);
  assign ad_o    = addr_ph ? ad_q : ((data_ph && we_q) ? wdata_q : '0);
  assign cbe_o   = addr_ph ? (we_q ? CMD_CFG_WR : CMD_CFG_RD) : 4'h0;
  assign idsel_o = addr_ph ? idsel_q : '0;
  assign irdy_o  = data_ph;
  assign rdata_o = rdata_q;

  p_req_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(ad_q));
  p_idsel_addr_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_ph |-> (idsel_o == '0));
endmodule

// File: tb/tb_cfg_cycle_gen.sv
module tb_cfg_cycle_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  bus = '0;
  logic [4:0]  dev = '0;
  logic [2:0]  fn = '0;
  logic [5:0]  rg = '0;
  logic [31:0] wdata = '0, rdata_in = '0;
  logic        devsel = 1'b0, trdy = 1'b0, rma_clr = 1'b0;
  logic [31:0] ad, rdata;
  logic        ad_oe, frame, irdy, busy, done, err, loc, rma;
  logic [3:0]  cbe;
  logic [20:0] idsel;

  int checks = 0, errors = 0, cyc = 0;
  bit rma_exp = 1'b0;

  always #10 clk = ~clk;

  cfg_cycle_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .bus_i(bus), .dev_i(dev),
    .fn_i(fn), .reg_i(rg), .wdata_i(wdata), .devsel_i(devsel), .trdy_i(trdy),
    .rdata_i(rdata_in), .rma_clr_i(rma_clr), .ad_o(ad), .ad_oe_o(ad_oe), .cbe_o(cbe),
    .frame_o(frame), .irdy_o(irdy), .idsel_o(idsel), .busy_o(busy), .done_o(done),
    .err_o(err), .local_o(loc), .rdata_o(rdata), .rma_o(rma)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic access(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                        input logic [5:0] r, input bit w, input logic [31:0] wd,
                        input int dly, input bit poke);
    logic [31:0] exp_ad, exp_id;
    int n_step, i, exp_i;
    bit ab;
    exp_ad = (b != 0) ? {1'b0, 7'b0, b, d, f, r, 2'b01} : {21'h1FFFFF, f, r, 2'b00};
    exp_id = (b == 0 && d >= 1 && d <= 21) ? (32'd1 << (d - 1)) : 32'd0;
    @(negedge clk);
    req = 1'b1; we = w; bus = b; dev = d; fn = f; rg = r; wdata = wd;
    rdata_in = wd ^ 32'hA5A5_0000;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    if (b == 0 && d == 0) begin
      chk(done && loc && !busy && !frame && !ad_oe && !err, "R4 local",
          {26'b0, done, loc, busy, frame, ad_oe, err}, 32'b110000);
      @(negedge clk);
      chk(!done && !busy, "R4 local no cycle", {30'b0, done, busy}, 0);
      return;
    end
    chk(busy, "R9 busy", {31'b0, busy}, 1);
    n_step = 0;
    while (busy && !frame && n_step < 10) begin
      chk(ad_oe && ad == exp_ad, "R1/R2 step addr", ad, exp_ad);
      chk({11'b0, idsel} == exp_id, "R3 idsel step", {11'b0, idsel}, exp_id);
      if (poke && n_step == 0) begin req = 1'b1; dev = ~d; bus = ~b; end
      else req = 1'b0;
      n_step++;
      @(negedge clk);
    end
    req = 1'b0;
    chk(n_step == 2, "R5 step count", n_step, 2);
    chk(frame && ad == exp_ad, (b != 0) ? "R1 type1 addr" : "R2 type0 addr", ad, exp_ad);
    chk({11'b0, idsel} == exp_id, "R3 idsel", {11'b0, idsel}, exp_id);
    chk(cbe == (w ? 4'hB : 4'hA), "R6 cmd", {28'b0, cbe}, w ? 4'hB : 4'hA);
    devsel = 1'b0; trdy = 1'b0;
    i = 0;
    forever begin
      @(negedge clk);
      if (done || i > 12) break;
      i++;
      chk(!frame && irdy && cbe == 4'h0 && idsel == '0, "R7 data phase",
          {27'b0, frame, irdy, 1'b0, (cbe == 0), (idsel == 0)}, 32'b01011);
      chk(ad_oe == w && (!w || ad == wd), "R7 write data", ad, wd);
      devsel = (i >= dly); trdy = (i >= dly);
    end
    devsel = 1'b0; trdy = 1'b0;
    ab = (dly > 5);
    exp_i = ab ? 6 : dly + 1;
    chk(done && i + 1 == exp_i, "R8/R9 completion time", i + 1, exp_i);
    chk(err == ab, "R9 err", {31'b0, err}, {31'b0, ab});
    if (ab) rma_exp = 1'b1;
    chk(rma == rma_exp, "R8 rma sticky", {31'b0, rma}, {31'b0, rma_exp});
    if (!w && !ab) chk(rdata == (wd ^ 32'hA5A5_0000), "R7 read data", rdata, wd ^ 32'hA5A5_0000);
    @(negedge clk);
    chk(!done && !busy, "R9/R10 idle after", {30'b0, done, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !frame && !ad_oe && !rma && idsel == '0 && !done, "R9 reset state",
        {26'b0, busy, frame, ad_oe, rma, (idsel != 0), done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    foreach (bus_set[k]) begin end
    for (int bi = 0; bi < 3; bi++) begin
      logic [7:0] bv;
      bv = (bi == 0) ? 8'd0 : (bi == 1) ? 8'd3 : 8'hFF;
      for (int dv = 0; dv < 32; dv++) begin
        access(bv, 5'(dv), 3'(dv % 8), 6'((dv * 5) % 64), dv[0],
               32'h1000_0000 + 32'(dv * 17 + bi), (dv % 7) + 1, 1'b0);
      end
    end
    // R10: request raised mid-cycle
    access(8'd0, 5'd7, 3'd2, 6'd9, 1'b1, 32'hCAFE_0001, 2, 1'b1);
    access(8'd4, 5'd1, 3'd0, 6'd1, 1'b0, 32'hCAFE_0002, 1, 1'b1);
    // R8: window edges and clear
    access(8'd0, 5'd21, 3'd7, 6'd63, 1'b0, 32'h0BAD_0003, 5, 1'b0);
    access(8'd0, 5'd22, 3'd1, 6'd2, 1'b0, 32'h0BAD_0004, 6, 1'b0);
    @(negedge clk); rma_clr = 1'b1;
    @(negedge clk); rma_clr = 1'b0; rma_exp = 1'b0;
    chk(!rma, "R8 rma clear", {31'b0, rma}, 0);
    access(8'd1, 5'd2, 3'd3, 6'd4, 1'b1, 32'h0BAD_0005, 3, 1'b0);
    chk(!rma, "R8 rma stays clear", {31'b0, rma}, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int bus_set[1];
endmodule